// File: doc/BRIEF.md
# Indirect Configuration Access Port

This block lets a processor on a plain 32-bit memory-mapped slave bus reach configuration space behind a host bridge through two registers. The processor first writes a configuration address into an address register. That address holds an enable bit, a bus number, a device number, a function number and a dword register index. It then reads or writes a data window. Each data-window access becomes exactly one configuration transaction on a downstream request/acknowledge interface. The transaction carries the latched address fields, a read/write flag, a 4-bit byte enable and lane-steered write data.

The data window accepts byte, halfword and word accesses. For narrow accesses, the low two bits of the slave address choose the starting byte lane. Reads always return the whole dword, and the requester picks out the bytes it needs. The slave bus is held, with no ready pulse, until the downstream side acknowledges, so only one transaction can be in flight. When the enable bit of the address register is clear, a data-window access finishes at once and issues no downstream request.

Top module: `cfgwin_port`

## Requirements
- R1: After reset, `sb_ready` and `dn_req` are low and the address register reads back as zero.
- R2: A slave write to byte offset 0x28 loads the address register with this layout: bit 31 is enable, bits 23:16 are bus, bits 15:11 are device, bits 10:8 are function and bits 7:2 are the dword register. On readback, bits 30:24 and 1:0 are zero.
- R3: With enable set, an access to the data window at offset 0x2C raises `dn_req` in the cycle after acceptance. `dn_req` carries the latched bus, device, function and register fields, and `dn_we` equals the slave write flag. Request and fields stay stable until `dn_ack`.
- R4: `sb_size` encodes 0 as byte, 1 as halfword and 2 or 3 as word. With off = `sb_addr[1:0]`: a word sets `dn_be` = 4'b1111; a byte sets bit off only; a halfword sets bits off and off+1, clipped to bit 3.
- R5: Write data arrives right-justified on `sb_wdata`. It is masked to the access size and shifted left by 8*off on `dn_wdata`. A word access is not shifted.
- R6: A window read returns `dn_rdata` on `sb_rdata` as the full 32-bit dword, unshifted, for every access size.
- R7: `sb_ready` is a one-cycle pulse. For a window access it rises in the cycle after the edge on which `dn_req` and `dn_ack` are both high. For a register access it rises in the cycle after acceptance.
- R8: With enable clear, a window access raises no `dn_req` and completes one cycle after acceptance. A read then returns 32'hFFFF_FFFF.
- R9: No new downstream request starts while one is outstanding. Each enabled window access produces exactly one rising edge of `dn_req`.
- R10: Accesses to any other offset complete one cycle after acceptance, read as zero and leave the address register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sb_valid | input | 1 | Slave access request, held until `sb_ready` |
| sb_write | input | 1 | 1 = write, 0 = read |
| sb_size | input | 2 | Access size: 0 byte, 1 halfword, 2/3 word |
| sb_addr | input | ADDR_W | Byte address within the bridge register space |
| sb_wdata | input | 32 | Right-justified write data |
| sb_ready | output | 1 | One-cycle completion pulse |
| sb_rdata | output | 32 | Read data, valid with `sb_ready` |
| dn_req | output | 1 | Downstream configuration request, held until `dn_ack` |
| dn_we | output | 1 | Downstream write flag |
| dn_bus | output | 8 | Bus number |
| dn_dev | output | 5 | Device number |
| dn_fn | output | 3 | Function number |
| dn_reg | output | 6 | Dword register index |
| dn_be | output | 4 | Byte enables |
| dn_wdata | output | 32 | Lane-steered write data |
| dn_ack | input | 1 | Downstream completion |
| dn_rdata | input | 32 | Downstream read dword, valid with `dn_ack` |

## Verification
Two things can fall in the same cycle here. First, the downstream acknowledge can arrive in the very first cycle that `dn_req` is visible, at the same edge where completion must be returned. Second, the completion of one access can be followed directly by the acceptance of the next slave access, which may rewrite the address register. The bench provokes the first case by answering with zero latency, and the second by writing a new address immediately after the ready pulse and then issuing another window access. It judges the result by the exact cycle of `sb_ready`, by the count of `dn_req` rising edges, and by whether the second request carries the new fields rather than the old ones.

// File: rtl/cfgwin_pkg.sv
package cfgwin_pkg;
  localparam int DW     = 32;
  localparam int LANES  = DW / 8;
  localparam int BUS_W  = 8;
  localparam int DEV_W  = 5;
  localparam int FN_W   = 3;
  localparam int REG_W  = 6;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } xfer_size_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_DONE = 2'd2
  } ctrl_state_e;

  typedef struct packed {
    logic             en;
    logic [BUS_W-1:0] bus;
    logic [DEV_W-1:0] dev;
    logic [FN_W-1:0]  fn;
    logic [REG_W-1:0] rg;
  } cfg_addr_t;

  function automatic logic [DW-1:0] addr_readback(input cfg_addr_t a);
    return {a.en, 7'b0, a.bus, a.dev, a.fn, a.rg, 2'b00};
  endfunction
endpackage

// File: rtl/cfgwin_addr_reg.sv
module cfgwin_addr_reg
  import cfgwin_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  output cfg_addr_t     addr_q
);
  logic unused_bits;
  assign unused_bits = ^{wdata[30:24], wdata[1:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
    end else if (we) begin
      addr_q.en  <= wdata[31];
      addr_q.bus <= wdata[23:16];
      addr_q.dev <= wdata[15:11];
      addr_q.fn  <= wdata[10:8];
      addr_q.rg  <= wdata[7:2];
    end
  end
endmodule

// File: rtl/cfgwin_lane_steer.sv
module cfgwin_lane_steer
  import cfgwin_pkg::*;
(
  input  xfer_size_e       size,
  input  logic [1:0]       off,
  input  logic [DW-1:0]    wdata,
  output logic [LANES-1:0] be,
  output logic [DW-1:0]    lane_data
);
  logic [2:0]    nbytes;
  logic [1:0]    off_eff;
  logic [DW-1:0] masked;

  always_comb begin
    case (size)
      SZ_BYTE: begin
        nbytes  = 3'd1;
        off_eff = off;
        masked  = {24'b0, wdata[7:0]};
      end
      SZ_HALF: begin
        nbytes  = 3'd2;
        off_eff = off;
        masked  = {16'b0, wdata[15:0]};
      end
      default: begin
        nbytes  = 3'd4;
        off_eff = 2'd0;
        masked  = wdata;
      end
    endcase
    lane_data = masked << {off_eff, 3'b000};
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign be[i] = (3'(i) >= {1'b0, off_eff}) &&
                   (3'(i) <  ({1'b0, off_eff} + nbytes));
  end
endmodule

// File: rtl/cfgwin_ctrl.sv
module cfgwin_ctrl
  import cfgwin_pkg::*;
#(
  parameter int                ADDR_W       = 8,
  parameter logic [ADDR_W-1:0] CFG_ADDR_OFS = 8'h28,
  parameter logic [ADDR_W-1:0] CFG_DATA_OFS = 8'h2C
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sb_valid,
  input  logic               sb_write,
  input  logic [ADDR_W-3:0]  sb_word,
  output logic               sb_ready,
  output logic [DW-1:0]      sb_rdata,
  input  cfg_addr_t          addr_q,
  input  logic [LANES-1:0]   be_c,
  input  logic [DW-1:0]      wdata_c,
  output logic               addr_we,
  output logic               dn_req,
  output logic               dn_we,
  output logic [BUS_W-1:0]   dn_bus,
  output logic [DEV_W-1:0]   dn_dev,
  output logic [FN_W-1:0]    dn_fn,
  output logic [REG_W-1:0]   dn_reg,
  output logic [LANES-1:0]   dn_be,
  output logic [DW-1:0]      dn_wdata,
  input  logic               dn_ack,
  input  logic [DW-1:0]      dn_rdata
);
  localparam logic [ADDR_W-3:0] ADDR_IDX = CFG_ADDR_OFS[ADDR_W-1:2];
  localparam logic [ADDR_W-3:0] DATA_IDX = CFG_DATA_OFS[ADDR_W-1:2];

  ctrl_state_e state;
  logic        hit_addr, hit_data, accept;

  assign hit_addr = (sb_word == ADDR_IDX);
  assign hit_data = (sb_word == DATA_IDX);
  assign accept   = (state == ST_IDLE) && sb_valid;
  assign addr_we  = accept && sb_write && hit_addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      sb_ready <= 1'b0;
      sb_rdata <= '0;
      dn_req   <= 1'b0;
      dn_we    <= 1'b0;
      dn_bus   <= '0;
      dn_dev   <= '0;
      dn_fn    <= '0;
      dn_reg   <= '0;
      dn_be    <= '0;
      dn_wdata <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          sb_ready <= 1'b0;
          if (sb_valid) begin
            if (hit_data && addr_q.en) begin
              dn_req   <= 1'b1;
              dn_we    <= sb_write;
              dn_bus   <= addr_q.bus;
              dn_dev   <= addr_q.dev;
              dn_fn    <= addr_q.fn;
              dn_reg   <= addr_q.rg;
              dn_be    <= be_c;
              dn_wdata <= wdata_c;
              state    <= ST_WAIT;
            end else begin
              sb_ready <= 1'b1;
              state    <= ST_DONE;
              if (hit_addr)      sb_rdata <= addr_readback(addr_q);
              else if (hit_data) sb_rdata <= '1;
              else               sb_rdata <= '0;
            end
          end
        end
        ST_WAIT: begin
          if (dn_ack) begin
            dn_req   <= 1'b0;
            sb_ready <= 1'b1;
            sb_rdata <= dn_rdata;
            state    <= ST_DONE;
          end
        end
        default: begin
          sb_ready <= 1'b0;
          state    <= ST_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/cfgwin_port.sv
module cfgwin_port
  import cfgwin_pkg::*;
#(
  parameter int                ADDR_W       = 8,
  parameter logic [ADDR_W-1:0] CFG_ADDR_OFS = 8'h28,
  parameter logic [ADDR_W-1:0] CFG_DATA_OFS = 8'h2C
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sb_valid,
  input  logic              sb_write,
  input  logic [1:0]        sb_size,
  input  logic [ADDR_W-1:0] sb_addr,
  input  logic [31:0]       sb_wdata,
  output logic              sb_ready,
  output logic [31:0]       sb_rdata,
  output logic              dn_req,
  output logic              dn_we,
  output logic [7:0]        dn_bus,
  output logic [4:0]        dn_dev,
  output logic [2:0]        dn_fn,
  output logic [5:0]        dn_reg,
  output logic [3:0]        dn_be,
  output logic [31:0]       dn_wdata,
  input  logic              dn_ack,
  input  logic [31:0]       dn_rdata
);
  cfg_addr_t        addr_q;
  logic             addr_we;
  logic [LANES-1:0] be_c;
  logic [DW-1:0]    wdata_c;

  cfgwin_addr_reg u_areg (
    .clk    (clk),
    .rst    (rst),
    .we     (addr_we),
    .wdata  (sb_wdata),
    .addr_q (addr_q)
  );

  cfgwin_lane_steer u_steer (
    .size      (xfer_size_e'(sb_size)),
    .off       (sb_addr[1:0]),
    .wdata     (sb_wdata),
    .be        (be_c),
    .lane_data (wdata_c)
  );

  cfgwin_ctrl #(
    .ADDR_W       (ADDR_W),
    .CFG_ADDR_OFS (CFG_ADDR_OFS),
    .CFG_DATA_OFS (CFG_DATA_OFS)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .sb_valid (sb_valid),
    .sb_write (sb_write),
    .sb_word  (sb_addr[ADDR_W-1:2]),
    .sb_ready (sb_ready),
    .sb_rdata (sb_rdata),
    .addr_q   (addr_q),
    .be_c     (be_c),
    .wdata_c  (wdata_c),
    .addr_we  (addr_we),
    .dn_req   (dn_req),
    .dn_we    (dn_we),
    .dn_bus   (dn_bus),
    .dn_dev   (dn_dev),
    .dn_fn    (dn_fn),
    .dn_reg   (dn_reg),
    .dn_be    (dn_be),
    .dn_wdata (dn_wdata),
    .dn_ack   (dn_ack),
    .dn_rdata (dn_rdata)
  );
endmodule

// File: rtl/cfgwin_checker.sv
module cfgwin_checker (
  input logic        clk,
  input logic        rst,
  input logic        sb_ready,
  input logic [31:0] sb_rdata,
  input logic        dn_req,
  input logic        dn_we,
  input logic [7:0]  dn_bus,
  input logic [4:0]  dn_dev,
  input logic [2:0]  dn_fn,
  input logic [5:0]  dn_reg,
  input logic [3:0]  dn_be,
  input logic [31:0] dn_wdata,
  input logic        dn_ack,
  input logic [31:0] dn_rdata,
  input logic        cfg_en
);
  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (!dn_req && !sb_ready));

  p_req_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (dn_req && !dn_ack) |=> (dn_req &&
      $stable({dn_we, dn_bus, dn_dev, dn_fn, dn_reg, dn_be, dn_wdata})));

  p_be_nonzero_r4: assert property (@(posedge clk) disable iff (rst)
    dn_req |-> (dn_be != 4'b0000));

  p_read_return_r6: assert property (@(posedge clk) disable iff (rst)
    (dn_req && dn_ack && !dn_we) |=> (sb_rdata == $past(dn_rdata)));

  p_ready_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    sb_ready |=> !sb_ready);

  p_done_after_ack_r7: assert property (@(posedge clk) disable iff (rst)
    (dn_req && dn_ack) |=> (sb_ready && !dn_req));

  p_start_enabled_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(dn_req) |-> cfg_en);

  p_single_outstanding_r9: assert property (@(posedge clk) disable iff (rst)
    dn_req |-> !sb_ready);
endmodule

bind cfgwin_port cfgwin_checker u_chk (
  .clk      (clk),
  .rst      (rst),
  .sb_ready (sb_ready),
  .sb_rdata (sb_rdata),
  .dn_req   (dn_req),
  .dn_we    (dn_we),
  .dn_bus   (dn_bus),
  .dn_dev   (dn_dev),
  .dn_fn    (dn_fn),
  .dn_reg   (dn_reg),
  .dn_be    (dn_be),
  .dn_wdata (dn_wdata),
  .dn_ack   (dn_ack),
  .dn_rdata (dn_rdata),
  .cfg_en   (addr_q.en)
);

// File: tb/cfgwin_port_test.sv
module cfgwin_port_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sb_valid = 1'b0, sb_write = 1'b0;
  logic [1:0]  sb_size = 2'd2;
  logic [7:0]  sb_addr = 8'h0;
  logic [31:0] sb_wdata = '0;
  logic        sb_ready;
  logic [31:0] sb_rdata;
  logic        dn_req, dn_we;
  logic [7:0]  dn_bus;
  logic [4:0]  dn_dev;
  logic [2:0]  dn_fn;
  logic [5:0]  dn_reg;
  logic [3:0]  dn_be;
  logic [31:0] dn_wdata;
  logic        dn_ack = 1'b0;
  logic [31:0] dn_rdata = '0;

  int n_checks = 0, n_fail = 0;
  int resp_lat = 0, wait_cnt = 0, req_count = 0, rise_count = 0;
  logic        prev_req = 1'b0;
  logic        cap_we;
  logic [7:0]  cap_bus;
  logic [4:0]  cap_dev;
  logic [2:0]  cap_fn;
  logic [5:0]  cap_reg;
  logic [3:0]  cap_be;
  logic [31:0] cap_wdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfgwin_port uut (
    .clk(clk), .rst(rst), .sb_valid(sb_valid), .sb_write(sb_write),
    .sb_size(sb_size), .sb_addr(sb_addr), .sb_wdata(sb_wdata),
    .sb_ready(sb_ready), .sb_rdata(sb_rdata), .dn_req(dn_req), .dn_we(dn_we),
    .dn_bus(dn_bus), .dn_dev(dn_dev), .dn_fn(dn_fn), .dn_reg(dn_reg),
    .dn_be(dn_be), .dn_wdata(dn_wdata), .dn_ack(dn_ack), .dn_rdata(dn_rdata)
  );

  function automatic logic [31:0] pattern(input logic [7:0] b, input logic [4:0] d,
                                          input logic [2:0] f, input logic [5:0] r);
    return {b, 3'b0, d, 5'b0, f, 2'b0, r} ^ 32'hC0DE_0000;
  endfunction

  // Downstream responder: acknowledges after resp_lat idle cycles
  initial begin
    forever begin
      @(negedge clk);
      if (dn_req && !prev_req) rise_count++;
      prev_req = dn_req;
      if (dn_ack) begin
        dn_ack = 1'b0;
      end else if (dn_req) begin
        if (wait_cnt >= resp_lat) begin
          dn_ack    = 1'b1;
          dn_rdata  = pattern(dn_bus, dn_dev, dn_fn, dn_reg);
          cap_we    = dn_we;   cap_bus = dn_bus; cap_dev = dn_dev;
          cap_fn    = dn_fn;   cap_reg = dn_reg; cap_be  = dn_be;
          cap_wdata = dn_wdata;
          req_count++;
          wait_cnt  = 0;
        end else begin
          wait_cnt++;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_access(input bit wr, input logic [1:0] sz, input logic [7:0] a,
                           input logic [31:0] wd, input int lat,
                           output logic [31:0] rd, output int cyc);
    @(negedge clk);
    resp_lat = lat;
    sb_valid = 1'b1; sb_write = wr; sb_size = sz; sb_addr = a; sb_wdata = wd;
    cyc = 0;
    rd  = '0;
    forever begin
      @(negedge clk);
      cyc++;
      if (sb_ready) begin
        rd = sb_rdata;
        break;
      end
      if (cyc > 100) begin
        chk(1'b0, "access timeout", 32'(cyc), 32'd100);
        break;
      end
    end
    sb_valid = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] rd; int cyc;
    chk(!sb_ready, "R1 ready after reset", 32'(sb_ready), 0);
    chk(!dn_req, "R1 req after reset", 32'(dn_req), 0);
    do_access(0, 2'd2, 8'h28, 0, 0, rd, cyc);
    chk(rd == 0, "R1 address reg reset value", rd, 0);
  endtask

  task automatic t_addr_reg();
    logic [31:0] rd; int cyc;
    do_access(1, 2'd2, 8'h28, 32'hFFFF_FFFF, 0, rd, cyc);
    chk(cyc == 1, "R7 register write latency", 32'(cyc), 1);
    do_access(0, 2'd2, 8'h28, 0, 0, rd, cyc);
    chk(rd == 32'h80FF_FFFC, "R2 reserved bits read zero", rd, 32'h80FF_FFFC);
    do_access(1, 2'd2, 8'h28, 32'h8012_AB5F, 0, rd, cyc);
    do_access(0, 2'd2, 8'h28, 0, 0, rd, cyc);
    chk(rd == 32'h8012_AB5C, "R2 address readback", rd, 32'h8012_AB5C);
  endtask

  task automatic t_word_read();
    logic [31:0] rd; int cyc; int r0;
    r0 = rise_count;
    do_access(0, 2'd2, 8'h2C, 0, 0, rd, cyc);
    chk(rd == pattern(8'h12, 5'h15, 3'd3, 6'h17), "R6 word read data", rd,
        pattern(8'h12, 5'h15, 3'd3, 6'h17));
    chk({cap_bus, cap_dev, cap_fn, cap_reg} == {8'h12, 5'h15, 3'd3, 6'h17},
        "R3 request fields", 32'({cap_bus, cap_dev, cap_fn, cap_reg}),
        32'({8'h12, 5'h15, 3'd3, 6'h17}));
    chk(cap_we == 1'b0, "R3 read flag", 32'(cap_we), 0);
    chk(cap_be == 4'hF, "R4 word enables", 32'(cap_be), 32'hF);
    chk(cyc == 2, "R7 zero-latency completion", 32'(cyc), 2);
    chk(rise_count - r0 == 1, "R9 one request per access", 32'(rise_count - r0), 1);
  endtask

  task automatic t_narrow_writes();
    logic [31:0] rd; int cyc; int r0;
    r0 = rise_count;
    do_access(1, 2'd0, 8'h2E, 32'hFFFF_FFA5, 2, rd, cyc);
    chk(cap_be == 4'b0100, "R4 byte enable lane 2", 32'(cap_be), 32'b0100);
    chk(cap_wdata == 32'h00A5_0000, "R5 byte steering", cap_wdata, 32'h00A5_0000);
    chk(cap_we == 1'b1, "R3 write flag", 32'(cap_we), 1);
    chk(cyc == 4, "R7 stall with latency 2", 32'(cyc), 4);
    do_access(1, 2'd1, 8'h2E, 32'hDEAD_1234, 0, rd, cyc);
    chk(cap_be == 4'b1100, "R4 halfword enables upper", 32'(cap_be), 32'b1100);
    chk(cap_wdata == 32'h1234_0000, "R5 halfword steering", cap_wdata, 32'h1234_0000);
    do_access(1, 2'd0, 8'h2F, 32'h0000_003C, 5, rd, cyc);
    chk(cap_be == 4'b1000, "R4 byte enable lane 3", 32'(cap_be), 32'b1000);
    chk(cap_wdata == 32'h3C00_0000, "R5 byte lane 3 steering", cap_wdata, 32'h3C00_0000);
    chk(cyc == 7, "R7 stall with latency 5", 32'(cyc), 7);
    chk(rise_count - r0 == 3, "R9 three requests for three accesses",
        32'(rise_count - r0), 3);
    do_access(1, 2'd1, 8'h2F, 32'h0000_ABCD, 0, rd, cyc);
    chk(cap_be == 4'b1000, "R4 halfword clipped at lane 3", 32'(cap_be), 32'b1000);
    do_access(1, 2'd2, 8'h2E, 32'h1122_3344, 0, rd, cyc);
    chk(cap_wdata == 32'h1122_3344 && cap_be == 4'hF, "R5 word unshifted",
        cap_wdata, 32'h1122_3344);
  endtask

  task automatic t_narrow_read();
    logic [31:0] rd; int cyc;
    do_access(0, 2'd1, 8'h2D, 0, 1, rd, cyc);
    chk(cap_be == 4'b0110, "R4 halfword enables middle", 32'(cap_be), 32'b0110);
    chk(rd == pattern(8'h12, 5'h15, 3'd3, 6'h17), "R6 halfword read full dword", rd,
        pattern(8'h12, 5'h15, 3'd3, 6'h17));
    do_access(0, 2'd0, 8'h2F, 0, 0, rd, cyc);
    chk(rd == pattern(8'h12, 5'h15, 3'd3, 6'h17), "R6 byte read full dword", rd,
        pattern(8'h12, 5'h15, 3'd3, 6'h17));
  endtask

  task automatic t_disabled();
    logic [31:0] rd; int cyc; int r0;
    do_access(1, 2'd2, 8'h28, 32'h0012_AB5C, 0, rd, cyc);
    r0 = rise_count;
    do_access(0, 2'd2, 8'h2C, 0, 0, rd, cyc);
    chk(rd == 32'hFFFF_FFFF, "R8 disabled read all ones", rd, 32'hFFFF_FFFF);
    chk(cyc == 1, "R8 disabled completes at once", 32'(cyc), 1);
    do_access(1, 2'd0, 8'h2D, 32'h55, 3, rd, cyc);
    chk(rise_count == r0, "R8 no request while disabled", 32'(rise_count), 32'(r0));
  endtask

  task automatic t_other_offsets();
    logic [31:0] rd; int cyc;
    do_access(1, 2'd2, 8'h30, 32'h8765_4321, 0, rd, cyc);
    chk(cyc == 1, "R10 other offset completes", 32'(cyc), 1);
    do_access(0, 2'd2, 8'h28, 0, 0, rd, cyc);
    chk(rd == 32'h0012_AB5C, "R10 address reg unchanged", rd, 32'h0012_AB5C);
    do_access(0, 2'd2, 8'h00, 0, 0, rd, cyc);
    chk(rd == 0, "R10 other offset reads zero", rd, 0);
  endtask

  task automatic t_back_to_back();
    logic [31:0] rd; int cyc; int r0;
    do_access(1, 2'd2, 8'h28, 32'h8003_1A08, 0, rd, cyc);
    r0 = rise_count;
    do_access(0, 2'd2, 8'h2C, 0, 0, rd, cyc);
    do_access(1, 2'd2, 8'h28, 32'h80FE_F9FC, 0, rd, cyc);
    do_access(0, 2'd2, 8'h2C, 0, 0, rd, cyc);
    chk({cap_bus, cap_dev, cap_fn, cap_reg} == {8'hFE, 5'h1F, 3'd1, 6'h3F},
        "R3 new address used after rewrite", 32'({cap_bus, cap_dev, cap_fn, cap_reg}),
        32'({8'hFE, 5'h1F, 3'd1, 6'h3F}));
    chk(rd == pattern(8'hFE, 5'h1F, 3'd1, 6'h3F), "R6 back-to-back read", rd,
        pattern(8'hFE, 5'h1F, 3'd1, 6'h3F));
    chk(rise_count - r0 == 2, "R9 back-to-back request count",
        32'(rise_count - r0), 2);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    chk(1'b0, "watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_addr_reg();
    t_word_read();
    t_narrow_writes();
    t_narrow_read();
    t_disabled();
    t_other_offsets();
    t_back_to_back();
    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule